// File: doc/BRIEF.md
# Observation Point Capture Chain

This block gives a test program a view of a set of internal nodes that are otherwise hard to observe. Each tapped node feeds one observation cell, which is a two-input selector in front of a D flip-flop. One select input sets the mode for every cell at once.

With the select low, each clock edge records the present logic value of every tapped node in its own cell. With the select high, the cells form one serial shift register. The recorded values then leave through a single serial output pin, one value per clock.

The block only taps the nodes and never drives them, so the functional logic is unchanged. A tester runs one capture cycle and then `NODES` shift cycles to read out the snapshot. While doing so it may push new bits in through the serial input.

Top module: `obs_chain`

## Requirements
- R1: An active-low asynchronous reset clears every cell to 0. While reset is held and straight after it is released, `sout` reads 0, and shifting with `sin` at 0 returns all zeros.
- R2: On a clock edge with `sel_shift` at 0, every cell i loads `node[i]`. After that edge `sout` equals the captured `node[NODES-1]`.
- R3: On a clock edge with `sel_shift` at 1, cell i loads the old value of cell i-1. After a capture, the k-th following shift edge places `node[NODES-1-k]` on `sout`, for k from 1 to NODES-1, so values leave in descending index order.
- R4: In shift mode cell 0 loads `sin`. A bit presented on `sin` at a shift edge appears on `sout` after NODES shift edges, and bits keep the order in which they entered.
- R5: `sout` is the output of the last cell's flop. It changes only at clock edges or on reset, and not when `node` or `sin` change between edges.
- R6: A capture edge overwrites every cell, even when the chain is part way through a shift. The next unload returns only the new snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every cell |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_shift | input | 1 | 0 selects capture, 1 selects shift |
| node | input | NODES | Tapped internal nodes; bit i feeds cell i |
| sin | input | 1 | Serial input into cell 0 |
| sout | output | 1 | Serial output taken from cell NODES-1 |

## Verification
A cell that held a wrong value would put a wrong bit on `sout` after a fixed number of shifts. For cell i that is NODES-1-i shifts after the capture edge, so a bad value in cell i is seen at a predictable clock. A link that skipped or repeated a cell, or that reversed the order, would put the nodes out of order within one unload of NODES cycles. A capture that failed to overwrite would leave old shifted bits on `sout` during the next unload.

// File: rtl/obs_chain.sv
module obs_chain #(
  parameter int NODES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_shift,
  input  logic [NODES-1:0] node,
  input  logic             sin,
  output logic             sout
);

  logic [NODES-1:0] cell_q;
  logic [NODES-1:0] link;

  assign link[0] = sin;

  generate
    for (genvar i = 1; i < NODES; i++) begin : g_link
      assign link[i] = cell_q[i-1];
    end
  endgenerate

  generate
    for (genvar i = 0; i < NODES; i++) begin : g_cell
      logic d;
      assign d = sel_shift ? link[i] : node[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q[i] <= 1'b0;
        else        cell_q[i] <= d;
      end
    end
  endgenerate

  assign sout = cell_q[NODES-1];

  a_r2_capture_all: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_shift |=> cell_q == $past(node));

  a_r2_capture_out: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_shift |=> sout == $past(node[NODES-1]));

  a_r4_serial_in: assert property (@(posedge clk) disable iff (!rst_n)
    sel_shift |=> cell_q[0] == $past(sin));

  generate
    if (NODES > 1) begin : g_chk
      a_r3_shift_out: assert property (@(posedge clk) disable iff (!rst_n)
        sel_shift |=> sout == $past(cell_q[NODES-2]));
    end
  endgenerate

endmodule

// File: tb/sim_obs_chain.sv
module sim_obs_chain;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_shift = 1'b0;
  logic [N-1:0] node = '0;
  logic sin = 1'b0;
  logic sout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  obs_chain #(.NODES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_shift(sel_shift),
    .node(node), .sin(sin), .sout(sout)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sout=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    sel_shift = 1'b0;
    node = '1;
    step();
    #3 rst_n = 1'b0;
    #1 check(sout, 1'b0, "R1 async clear");
    step();
    check(sout, 1'b0, "R1 held in reset");
    rst_n = 1'b1;
    sel_shift = 1'b1;
    sin = 1'b0;
    for (int k = 0; k < N; k++) begin
      step();
      check(sout, 1'b0, "R1 zeros shifted");
    end
  endtask

  task automatic t_unload(input logic [N-1:0] pat);
    sel_shift = 1'b0;
    node = pat;
    step();
    check(sout, pat[N-1], "R2 capture top");
    sel_shift = 1'b1;
    for (int k = 1; k < N; k++) begin
      node = ~node;
      step();
      check(sout, pat[N-1-k], "R3 descending order");
    end
  endtask

  task automatic t_serial(input logic [N-1:0] w);
    sel_shift = 1'b1;
    for (int k = 0; k < N; k++) begin
      sin = w[k];
      step();
    end
    check(sout, w[0], "R4 first bit through");
    sin = 1'b0;
    for (int k = 1; k < N; k++) begin
      step();
      check(sout, w[k], "R4 bit order");
    end
  endtask

  task automatic t_stable();
    sel_shift = 1'b0;
    node = 8'h80;
    step();
    check(sout, 1'b1, "R5 after capture");
    #2 node = 8'h00;
    sin = 1'b0;
    #2 check(sout, 1'b1, "R5 no change between edges");
    sel_shift = 1'b1;
    #2 check(sout, 1'b1, "R5 select change no effect");
  endtask

  task automatic t_recapture(input logic [N-1:0] a, input logic [N-1:0] b);
    sel_shift = 1'b0;
    node = a;
    step();
    sel_shift = 1'b1;
    sin = 1'b1;
    step();
    step();
    step();
    sin = 1'b0;
    t_unload(b);
    check(sout, b[0], "R6 new snapshot only");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(sout, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    t_unload(8'hA5);
    t_unload(8'h3C);
    t_unload(8'h01);
    t_unload(8'h80);
    t_serial(8'b1101_0010);
    t_stable();
    t_recapture(8'hFF, 8'h5A);
    t_reset();
    t_unload(8'hC3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule